// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a register-mapped SPI master for a host bus that issues single-cycle 32-bit reads and writes at word-aligned byte addresses. Software queues bytes into a 256-entry transmit FIFO. A serial engine shifts each byte out on MOSI while it shifts a byte in from MISO, and it pushes that byte into a 256-entry receive FIFO. Software then pops the received bytes through the receive data register.

A control bit can hold transfers back. While that bit is set, written bytes only accumulate. Once it is cleared, the engine sends bytes one after another until the transmit FIFO is empty. Two further control bits flush either FIFO and are never stored. The slave-select register drives active-low select lines directly, and software alone decides when a slave is selected.

Three single-cycle event pulses go to an external interrupt block: transmit drained, receive overrun and receive full. Register read data is registered and appears one clock after the read strobe.

Top module: `spi_fifo_master`

## Requirements
- R1: Register byte addresses are decoded exactly: 0x60 control, 0x64 status, 0x68 transmit data (reads 0), 0x6C receive data, 0x70 slave select, 0x74 transmit count, 0x78 receive count. Address 0x40 and all other addresses read 0 and ignore writes. Read data appears on reg_rdata_o in the clock after reg_re_i and is 0 in a clock that follows no read.
- R2: A write to 0x68 queues bits 7:0 of the write data. The transmit FIFO holds 256 bytes, and a write while it is full is dropped. Addresses 0x74 and 0x78 read the current byte counts (0 to 256).
- R3: While control bit 8 is 1, no transfer starts. While it is 0 and the transmit FIFO is not empty, the engine pops one byte and starts a transfer. It keeps doing so until the FIFO is empty.
- R4: Transfers use SPI mode 0, most significant bit first. Each bit lasts 4 clocks: SCLK is low for 2 clocks and then high for 2. MISO is sampled in the first high clock. A byte occupies 32 clocks, and one idle clock follows it before the next byte starts. SCLK and MOSI are 0 while idle.
- R5: At the end of each byte, the captured byte is pushed into the receive FIFO.
- R6: If the receive FIFO holds 256 bytes when a byte ends, that byte is dropped and evt_rx_overrun_o pulses for one clock in the following clock. This applies even if a pop happens in the same clock.
- R7: If a byte ends when the receive FIFO holds 255 bytes and no receive pop happens in that clock, evt_rx_full_o pulses in the following clock. The two receive events never pulse together.
- R8: If a byte ends while the transmit FIFO is empty, evt_tx_empty_o pulses in the following clock.
- R9: Status reads {28'b0, tx_full, tx_empty, rx_full, rx_empty}, with bit 3 set when the transmit FIFO is full and bit 0 set when the receive FIFO is empty. Writes to status are ignored.
- R10: A read of 0x6C returns the oldest received byte and pops it. On an empty FIFO it returns 0 and changes nothing. A pop and a push in the same clock leave the count unchanged.
- R11: Writing control bit 5 flushes the transmit FIFO and bit 6 flushes the receive FIFO. Neither bit is stored; the other control bits are stored as written.
- R12: Slave select resets to all ones, and ss_no_o[i] equals bit i of that register.
- R13: After reset, control is 0, both FIFOs are empty, and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one clock after the strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no_o | output | NUM_SS | Active-low slave selects |
| evt_tx_empty_o | output | 1 | Transmit drained pulse |
| evt_rx_overrun_o | output | 1 | Receive overrun pulse |
| evt_rx_full_o | output | 1 | Receive full pulse |

## Verification
The delicate collision is a software pop of the receive data register in the same clock as the engine pushes a completed byte. The bench times a read strobe to land on the last clock of a byte, first with one byte waiting and then in other states. It judges the result by the byte returned, the unchanged count and the order of the remaining bytes. A behavioural queue model predicts every output on every clock. The same model also settles the boundary between a full receive FIFO and a 255-byte receive FIFO, which decides whether a byte ending in that clock raises overrun or receive-full.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_SWRST = 8'h40;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h60;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h64;
  localparam logic [REG_AW-1:0] OFS_TXD   = 8'h68;
  localparam logic [REG_AW-1:0] OFS_RXD   = 8'h6C;
  localparam logic [REG_AW-1:0] OFS_SSEL  = 8'h70;
  localparam logic [REG_AW-1:0] OFS_TXOCC = 8'h74;
  localparam logic [REG_AW-1:0] OFS_RXOCC = 8'h78;

  localparam int CTRL_TXRST   = 5;
  localparam int CTRL_RXRST   = 6;
  localparam int CTRL_INHIBIT = 8;

  typedef struct packed {
    logic tx_full;
    logic tx_empty;
    logic rx_full;
    logic rx_empty;
  } stat_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DIV  = 4,
  parameter int W    = 8,
  localparam int PW  = $clog2(DIV),
  localparam int BW  = $clog2(W),
  localparam int HALF = DIV / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic         sclk_o,
  output logic         mosi_o
);
  logic          busy_q;
  logic [PW-1:0] phase_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  tx_sh_q, rx_sh_q;
  logic          bit_end;

  assign bit_end = (phase_q == PW'(DIV - 1));
  assign busy_o  = busy_q;
  assign done_o  = busy_q && bit_end && (bit_q == BW'(W - 1));
  assign rx_o    = rx_sh_q;
  assign sclk_o  = busy_q && (phase_q >= PW'(HALF));
  assign mosi_o  = busy_q && tx_sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      bit_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= '0;
        bit_q   <= '0;
        tx_sh_q <= data_i;
        rx_sh_q <= '0;
      end
    end else begin
      // sample in the first clock with SCLK high
      if (phase_q == PW'(HALF)) rx_sh_q <= {rx_sh_q[W-2:0], miso_i};
      if (bit_end) begin
        phase_q <= '0;
        if (bit_q == BW'(W - 1)) begin
          busy_q <= 1'b0;
        end else begin
          bit_q   <= bit_q + BW'(1);
          tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
        end
      end else begin
        phase_q <= phase_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int NUM_SS   = 4,
  parameter int SCLK_DIV = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no_o,
  output logic              evt_tx_empty_o,
  output logic              evt_rx_overrun_o,
  output logic              evt_rx_full_o
);
  localparam logic [31:0] CTRL_KEEP =
    ~((32'd1 << CTRL_TXRST) | (32'd1 << CTRL_RXRST));

  logic [31:0]       ctrl_q, rdata_q, rd_val;
  logic [NUM_SS-1:0] ss_q;
  logic              txe_q, ovr_q, rxf_q;
  logic              wr_ctrl, wr_txd, wr_ss, rd_rxd;
  logic              tx_flush, rx_flush, inhibit, start;
  logic [7:0]        tx_head, rx_head, eng_rx;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              busy, done;
  stat_t             stat;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign wr_txd   = reg_we_i && (reg_addr_i == OFS_TXD);
  assign wr_ss    = reg_we_i && (reg_addr_i == OFS_SSEL);
  assign rd_rxd   = reg_re_i && (reg_addr_i == OFS_RXD);
  assign tx_flush = wr_ctrl && reg_wdata_i[CTRL_TXRST];
  assign rx_flush = wr_ctrl && reg_wdata_i[CTRL_RXRST];
  assign inhibit  = ctrl_q[CTRL_INHIBIT];
  assign start    = !busy && !inhibit && !tx_empty;

  byte_fifo #(.DEPTH(DEPTH), .W(8)) tx_fifo_i (
    .clk_i, .rst_ni,
    .flush_i(tx_flush), .push_i(wr_txd), .data_i(reg_wdata_i[7:0]),
    .pop_i(start), .data_o(tx_head), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(8)) rx_fifo_i (
    .clk_i, .rst_ni,
    .flush_i(rx_flush), .push_i(done), .data_i(eng_rx),
    .pop_i(rd_rxd), .data_o(rx_head), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_shifter #(.DIV(SCLK_DIV), .W(8)) eng_i (
    .clk_i, .rst_ni,
    .start_i(start), .data_i(tx_head), .miso_i,
    .busy_o(busy), .done_o(done), .rx_o(eng_rx),
    .sclk_o, .mosi_o
  );

  assign stat = '{tx_full: tx_full, tx_empty: tx_empty,
                  rx_full: rx_full, rx_empty: rx_empty};

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTRL:  rd_val = ctrl_q;
      OFS_STAT:  rd_val = 32'(stat);
      OFS_RXD:   rd_val = rx_empty ? 32'd0 : 32'(rx_head);
      OFS_SSEL:  rd_val = 32'(ss_q);
      OFS_TXOCC: rd_val = 32'(tx_cnt);
      OFS_RXOCC: rd_val = 32'(rx_cnt);
      default:   rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ss_q    <= '1;
      rdata_q <= '0;
      txe_q   <= 1'b0;
      ovr_q   <= 1'b0;
      rxf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i & CTRL_KEEP;
      if (wr_ss)   ss_q   <= reg_wdata_i[NUM_SS-1:0];
      rdata_q <= reg_re_i ? rd_val : 32'd0;
      txe_q   <= done && tx_empty;
      ovr_q   <= done && rx_full;
      rxf_q   <= done && (rx_cnt == CW'(DEPTH - 1)) && !rd_rxd;
    end
  end

  assign reg_rdata_o      = rdata_q;
  assign ss_no_o          = ss_q;
  assign evt_tx_empty_o   = txe_q;
  assign evt_rx_overrun_o = ovr_q;
  assign evt_rx_full_o    = rxf_q;
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sclk_i,
  input logic          mosi_i,
  input logic          busy_i,
  input logic          inhibit_i,
  input logic [CW-1:0] tx_cnt_i,
  input logic [CW-1:0] rx_cnt_i,
  input logic          txe_i,
  input logic          ovr_i,
  input logic          rxf_i
);
  AST_TX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CW'(DEPTH)); // R2
  AST_NO_START_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && !busy_i) |=> !busy_i); // R3
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_i); // R4
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && $past(sclk_i)) |-> $stable(mosi_i)); // R4
  AST_OVR_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |-> ($past(rx_cnt_i) == CW'(DEPTH))); // R6
  AST_RXF_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_i |-> ($past(rx_cnt_i) == CW'(DEPTH - 1))); // R7
  AST_RX_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovr_i && rxf_i)); // R7
  AST_TXE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txe_i |-> ($past(tx_cnt_i) == '0)); // R8
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_o), .mosi_i(mosi_o),
  .busy_i(busy), .inhibit_i(inhibit), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
  .txe_i(evt_tx_empty_o), .ovr_i(evt_rx_overrun_o), .rxf_i(evt_rx_full_o)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  ss_n;
  logic        e_txe, e_ovr, e_rxf;

  int compared = 0, mismatched = 0;
  int n_txe = 0, n_ovr = 0, n_rxf = 0;

  always #5 clk = ~clk;
  assign miso = ~mosi;  // inverted loopback slave

  spi_fifo_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_re_i(re), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_no_o(ss_n),
    .evt_tx_empty_o(e_txe), .evt_rx_overrun_o(e_ovr), .evt_rx_full_o(e_rxf)
  );

  // behavioural reference model
  logic [7:0]  m_tx[$];
  logic [7:0]  m_rx[$];
  bit          m_busy = 0;
  int          m_cnt = 0;
  logic [7:0]  m_sh = '0, m_rsh = '0;
  logic [31:0] m_ctrl = '0, m_rdata = '0;
  logic [3:0]  m_ss = '1;
  bit          m_txe = 0, m_ovr = 0, m_rxf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx.delete(); m_rx.delete();
      m_busy = 0; m_cnt = 0; m_sh = '0; m_rsh = '0;
      m_ctrl = '0; m_rdata = '0; m_ss = '1;
      m_txe = 0; m_ovr = 0; m_rxf = 0;
    end else begin
      automatic bit done  = m_busy && m_cnt == 31;
      automatic bit start = !m_busy && !m_ctrl[8] && m_tx.size() > 0;
      automatic int txn = m_tx.size();
      automatic int rxn = m_rx.size();
      automatic bit pop = re && addr == 8'h6C && rxn > 0;
      automatic logic [7:0] sb = start ? m_tx[0] : 8'h00;
      automatic logic [31:0] rv = 0;
      if (re) case (addr)
        8'h60: rv = m_ctrl;
        8'h64: rv = {28'd0, txn == 256, txn == 0, rxn == 256, rxn == 0};
        8'h6C: rv = (rxn > 0) ? {24'd0, m_rx[0]} : 32'd0;
        8'h70: rv = {28'd0, m_ss};
        8'h74: rv = txn;
        8'h78: rv = rxn;
        default: rv = 0;
      endcase
      m_rdata = rv;
      m_ovr = done && rxn == 256;
      m_rxf = done && rxn == 255 && !(re && addr == 8'h6C);
      m_txe = done && txn == 0;
      if (we && addr == 8'h60 && wdata[5]) m_tx.delete();
      else begin
        if (start) void'(m_tx.pop_front());
        if (we && addr == 8'h68 && txn < 256) m_tx.push_back(wdata[7:0]);
      end
      if (we && addr == 8'h60 && wdata[6]) m_rx.delete();
      else begin
        if (pop) void'(m_rx.pop_front());
        if (done && rxn < 256) m_rx.push_back(m_rsh);
      end
      if (we && addr == 8'h60) m_ctrl = wdata & ~32'h60;
      if (we && addr == 8'h70) m_ss = wdata[3:0];
      if (start) begin
        m_busy = 1; m_cnt = 0; m_sh = sb; m_rsh = '0;
      end else if (m_busy) begin
        if (m_cnt % 4 == 2) m_rsh = {m_rsh[6:0], miso};
        if (m_cnt == 31) m_busy = 0; else m_cnt++;
      end
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    cmp(32'(sclk), 32'(m_busy && (m_cnt % 4) >= 2), "R4 sclk");
    cmp(32'(mosi), 32'(m_busy ? m_sh[7 - m_cnt / 4] : 1'b0), "R4 mosi");
    cmp(32'(ss_n), 32'(m_ss), "R12 ss");
    cmp(32'(e_ovr), 32'(m_ovr), "R6 overrun evt");
    cmp(32'(e_rxf), 32'(m_rxf), "R7 rx full evt");
    cmp(32'(e_txe), 32'(m_txe), "R8 tx empty evt");
    cmp(rdata, m_rdata, "R1 rdata");
    n_txe += int'(e_txe); n_ovr += int'(e_ovr); n_rxf += int'(e_rxf);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0;
    cmp(rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_byte_end;
    @(negedge clk);
    while (!(m_busy && m_cnt == 31)) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1_500_000;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R13 reset state
    rd(8'h64, 32'h5, "R13 status after reset");
    rd(8'h70, 32'hF, "R12 select reset");
    rd(8'h60, 32'h0, "R13 control after reset");
    // R3 inhibit holds bytes
    wr(8'h60, 32'h100);
    wr(8'h68, 32'h1A5); wr(8'h68, 32'h3C); wr(8'h68, 32'h81);
    idle(40);
    rd(8'h74, 32'd3, "R3 tx count held");
    rd(8'h78, 32'd0, "R3 nothing received");
    rd(8'h64, 32'h1, "R9 status queued");
    // R9 / R1 ignored writes
    wr(8'h64, 32'hF); wr(8'h40, 32'hFFFF);
    rd(8'h64, 32'h1, "R9 status write ignored");
    rd(8'h40, 32'h0, "R1 reset reg reads 0");
    rd(8'h68, 32'h0, "R1 tx data reads 0");
    // release: drain
    wr(8'h60, 32'h0);
    idle(120);
    rd(8'h78, 32'd3, "R5 rx count");
    rd(8'h6C, 32'h5A, "R2 R4 first byte");
    rd(8'h6C, 32'hC3, "R4 second byte");
    rd(8'h6C, 32'h7E, "R4 third byte");
    rd(8'h6C, 32'h0, "R10 empty read");
    rd(8'h64, 32'h5, "R10 empty status");
    // R12 select lines
    wr(8'h70, 32'h6);
    cmp(32'(ss_n), 32'h6, "R12 select follows reg");
    wr(8'h70, 32'hF);
    // R2 full tx, R11 flush
    wr(8'h60, 32'h100);
    for (int i = 0; i < 257; i++) wr(8'h68, 32'(i));
    rd(8'h74, 32'd256, "R2 tx capacity");
    rd(8'h64, 32'h9, "R9 tx full status");
    wr(8'h60, 32'h120);
    rd(8'h74, 32'd0, "R11 tx flushed");
    rd(8'h60, 32'h100, "R11 reset bits not stored");
    // R7 fill rx
    for (int i = 0; i < 256; i++) wr(8'h68, 32'(i));
    n_txe = 0; n_ovr = 0; n_rxf = 0;
    wr(8'h60, 32'h0);
    idle(256 * 33 + 20);
    cmp(32'(n_rxf), 32'd1, "R7 one full event");
    cmp(32'(n_txe), 32'd1, "R8 one drained event");
    cmp(32'(n_ovr), 32'd0, "R6 no overrun yet");
    rd(8'h78, 32'd256, "R7 rx count full");
    rd(8'h64, 32'h6, "R9 rx full status");
    // R6 overrun
    n_txe = 0; n_ovr = 0; n_rxf = 0;
    wr(8'h68, 32'hAA); wr(8'h68, 32'hBB);
    idle(90);
    cmp(32'(n_ovr), 32'd2, "R6 overrun events");
    cmp(32'(n_rxf), 32'd0, "R7 no full event on overrun");
    rd(8'h78, 32'd256, "R6 count kept");
    rd(8'h6C, 32'hFF, "R6 oldest byte kept");
    // R11 rx flush
    wr(8'h60, 32'h40);
    rd(8'h78, 32'd0, "R11 rx flushed");
    // R10 pop and push in the same clock
    wr(8'h60, 32'h100);
    wr(8'h68, 32'h11); wr(8'h68, 32'h22); wr(8'h68, 32'h33); wr(8'h68, 32'h44);
    wr(8'h60, 32'h0);
    wait_byte_end();
    wait_byte_end();
    re = 1; addr = 8'h6C;
    @(negedge clk); re = 0;
    cmp(rdata, 32'hEE, "R10 pop at byte end");
    idle(80);
    rd(8'h78, 32'd3, "R10 count after collision");
    rd(8'h6C, 32'hDD, "R10 order after collision");
    idle(5);
    finish_run();
  end
endmodule